// File: doc/BRIEF.md
# Serial Row-Scan LCD Refresh Controller

This block keeps a row-scanned monochrome LCD matrix refreshed over a four-wire serial link. The link has a data line, a shift clock, a row latch strobe and a first-row marker. A free-running line timer divides time into fixed periods of `LINE_CYCLES` system clocks. In each period the block reads one row of pixels from a frame buffer, one byte per read, and shifts each byte out most significant bit first as its own burst of eight shift-clock pulses. At the end of the period a latch pulse of `LP_WIDTH` clocks moves the row into the panel's drivers.

The latch strobe comes only from the line timer, so its period has no jitter whatever the shift activity. The first-row marker stays high for the whole period of row 0. It falls at the same clock edge as the latch pulse that commits row 0, which lets the panel reset its row pointer. After the last of `ROWS` rows the scan returns to row 0. A one-cycle frame-start pulse marks the beginning of each frame.

The frame buffer is an external synchronous read port. Data must appear on `fb_data` one clock after a cycle with `fb_rd` high. Parameters must satisfy `(BITS_PER_ROW/8)*(2+16*SCP_HALF) + 1 <= LINE_CYCLES - LP_WIDTH`. `SCP_HALF` should give a shift clock of at most 2 MHz, which is 50 clocks at 200 MHz.

Top module: `lcd_row_refresh`

## Requirements
- R1: While `rst_n` is low, `lcd_lp`, `lcd_scp`, `lcd_din` and `fb_rd` are 0. The cycle right after reset is released is the first cycle of the period for row 0.
- R2: `lcd_lp` is high for exactly the last `LP_WIDTH` cycles of every period of `LINE_CYCLES` cycles. Outside those cycles it is low.
- R3: In each period, `fb_rd` pulses for one cycle once per byte, `BITS_PER_ROW/8` times in all. Pulse k (counting from 0) carries `fb_addr = row*(BITS_PER_ROW/8) + k`. The first pulse comes in the second cycle of the period. Each later pulse comes `2+16*SCP_HALF` cycles after the one before it.
- R4: `lcd_flm` is 1 during the whole period of row 0 and 0 in every other period. It therefore falls at the same clock edge as the `lcd_lp` that latches row 0.
- R5: `frame_start` is 1 only in the first cycle of the period of row 0.
- R6: `lcd_scp` pulses 8 times per byte. Each pulse is high for `SCP_HALF` cycles and then low for `SCP_HALF` cycles. The first rising edge comes two cycles after that byte's `fb_rd`. Between bytes, `lcd_scp` stays low.
- R7: `lcd_din` changes only at the clock edge where `lcd_scp` rises. It carries the bits of each byte from bit 7 down to bit 0 and holds its last value between bursts and between rows.
- R8: The row after row `ROWS-1` is row 0. Its first fetch is from address 0.
- R9: Every row's `BITS_PER_ROW` shift pulses finish before `lcd_lp` rises. While `lcd_lp` is high, `lcd_scp` and `fb_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_rd | output | 1 | Frame buffer read strobe |
| fb_addr | output | $clog2(ROWS*BITS_PER_ROW/8) | Frame buffer byte address |
| fb_data | input | 8 | Frame buffer data, valid one cycle after `fb_rd` |
| lcd_din | output | 1 | Serial pixel data |
| lcd_scp | output | 1 | Shift clock; the panel samples on the falling edge |
| lcd_lp | output | 1 | Row latch pulse; the panel latches on the falling edge |
| lcd_flm | output | 1 | First-row marker |
| frame_start | output | 1 | One-cycle pulse at the start of each frame |

## Verification
At the boundary between periods, several things happen at one clock edge. The latch pulse falls, the row index advances, the first-row marker rises or falls, and the fetch for the new row begins. When the scan wraps from row `ROWS-1` to row 0, the frame-start pulse also comes in the next cycle. The bench runs several full frames and a reset in the middle of shifting, so each of these pile-ups happens more than once. On every clock a behavioural model built from the period index and the offset within the period gives the expected value of every output. The bench compares all outputs against that model, so an output that is off by one cycle at a boundary shows up as a mismatch at that exact cycle.

// File: rtl/lcd_refresh_pkg.sv
package lcd_refresh_pkg;

  typedef enum logic [2:0] {
    SH_IDLE,
    SH_FETCH,
    SH_LOAD,
    SH_HIGH,
    SH_LOW
  } shift_state_e;

  // byte address of byte idx inside a row
  function automatic int unsigned byte_addr(int unsigned row, int unsigned idx,
                                            int unsigned per_row);
    return row * per_row + idx;
  endfunction

  // row index that follows row, wrapping after rows-1
  function automatic int unsigned next_row(int unsigned row, int unsigned rows);
    return (row == rows - 1) ? 0 : row + 1;
  endfunction

endpackage

// File: rtl/lcd_line_timer.sv
module lcd_line_timer #(
  parameter int LINE_CYCLES = 200000,
  parameter int LP_WIDTH    = 40,
  parameter int ROWS        = 24,
  localparam int CNT_W      = $clog2(LINE_CYCLES),
  localparam int ROW_W      = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             line_start,
  output logic             lp,
  output logic [ROW_W-1:0] row_idx
);
  import lcd_refresh_pkg::*;

  logic [CNT_W-1:0] tcnt;
  logic             period_end;

  assign period_end = (tcnt == CNT_W'(LINE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt       <= '0;
      line_start <= 1'b1;
      row_idx    <= '0;
    end else begin
      tcnt       <= period_end ? '0 : tcnt + 1'b1;
      line_start <= period_end;
      if (period_end)
        row_idx <= ROW_W'(next_row(32'(row_idx), ROWS));
    end
  end

  assign lp = (tcnt >= CNT_W'(LINE_CYCLES - LP_WIDTH));

endmodule

// File: rtl/lcd_row_shifter.sv
module lcd_row_shifter #(
  parameter int BYTES_PER_ROW = 5,
  parameter int SCP_HALF      = 50,
  parameter int ROW_W         = 5,
  parameter int ADDR_W        = 7,
  localparam int BI_W         = (BYTES_PER_ROW > 1) ? $clog2(BYTES_PER_ROW) : 1,
  localparam int H_W          = (SCP_HALF > 1) ? $clog2(SCP_HALF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [ROW_W-1:0]  row_idx,
  input  logic [7:0]        fb_data,
  output logic              fb_rd,
  output logic [ADDR_W-1:0] fb_addr,
  output logic              din,
  output logic              scp
);
  import lcd_refresh_pkg::*;

  shift_state_e    state;
  logic [BI_W-1:0] byte_idx;
  logic [2:0]      bits_left;
  logic [H_W-1:0]  hcnt;
  logic [6:0]      shreg;
  logic            half_done;
  logic            last_byte;

  assign half_done = (hcnt == H_W'(SCP_HALF - 1));
  assign last_byte = (byte_idx == BI_W'(BYTES_PER_ROW - 1));
  assign fb_rd     = (state == SH_FETCH);
  assign fb_addr   = ADDR_W'(byte_addr(32'(row_idx), 32'(byte_idx), BYTES_PER_ROW));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SH_IDLE;
      byte_idx  <= '0;
      bits_left <= '0;
      hcnt      <= '0;
      shreg     <= '0;
      din       <= 1'b0;
      scp       <= 1'b0;
    end else begin
      unique case (state)
        SH_IDLE: begin
          if (line_start) begin
            byte_idx <= '0;
            state    <= SH_FETCH;
          end
        end
        SH_FETCH: state <= SH_LOAD;
        SH_LOAD: begin
          din       <= fb_data[7];
          shreg     <= fb_data[6:0];
          bits_left <= 3'd7;
          scp       <= 1'b1;
          hcnt      <= '0;
          state     <= SH_HIGH;
        end
        SH_HIGH: begin
          hcnt <= half_done ? '0 : hcnt + 1'b1;
          if (half_done) begin
            scp   <= 1'b0;
            state <= SH_LOW;
          end
        end
        SH_LOW: begin
          hcnt <= half_done ? '0 : hcnt + 1'b1;
          if (half_done) begin
            if (bits_left != 3'd0) begin
              din       <= shreg[6];
              shreg     <= {shreg[5:0], 1'b0};
              bits_left <= bits_left - 3'd1;
              scp       <= 1'b1;
              state     <= SH_HIGH;
            end else if (last_byte) begin
              state <= SH_IDLE;
            end else begin
              byte_idx <= byte_idx + 1'b1;
              state    <= SH_FETCH;
            end
          end
        end
        default: state <= SH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lcd_row_refresh.sv
module lcd_row_refresh #(
  parameter int ROWS         = 24,
  parameter int BITS_PER_ROW = 40,
  parameter int LINE_CYCLES  = 200000,
  parameter int LP_WIDTH     = 40,
  parameter int SCP_HALF     = 50,
  localparam int BYTES_PER_ROW = BITS_PER_ROW / 8,
  localparam int ROW_W         = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int ADDR_W        = $clog2(ROWS * BYTES_PER_ROW)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              fb_rd,
  output logic [ADDR_W-1:0] fb_addr,
  input  logic [7:0]        fb_data,
  output logic              lcd_din,
  output logic              lcd_scp,
  output logic              lcd_lp,
  output logic              lcd_flm,
  output logic              frame_start
);

  // internal events brought out for the checker
  logic             line_start;
  logic [ROW_W-1:0] row_idx;
  logic             row_is_first;

  lcd_line_timer #(
    .LINE_CYCLES(LINE_CYCLES),
    .LP_WIDTH   (LP_WIDTH),
    .ROWS       (ROWS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_start(line_start),
    .lp        (lcd_lp),
    .row_idx   (row_idx)
  );

  lcd_row_shifter #(
    .BYTES_PER_ROW(BYTES_PER_ROW),
    .SCP_HALF     (SCP_HALF),
    .ROW_W        (ROW_W),
    .ADDR_W       (ADDR_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_start(line_start),
    .row_idx   (row_idx),
    .fb_data   (fb_data),
    .fb_rd     (fb_rd),
    .fb_addr   (fb_addr),
    .din       (lcd_din),
    .scp       (lcd_scp)
  );

  assign row_is_first = (row_idx == '0);
  assign lcd_flm      = row_is_first;
  assign frame_start  = line_start & row_is_first;

endmodule

// File: rtl/lcd_row_refresh_chk.sv
module lcd_row_refresh_chk #(
  parameter int SCP_HALF = 50,
  parameter int LP_WIDTH = 40,
  localparam int C_W     = $clog2(SCP_HALF + LP_WIDTH + 2)
) (
  input logic clk,
  input logic rst_n,
  input logic lcd_din,
  input logic lcd_scp,
  input logic lcd_lp,
  input logic lcd_flm,
  input logic frame_start,
  input logic fb_rd,
  input logic line_start
);

  logic [C_W-1:0] hi_cnt;
  logic [C_W-1:0] lp_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lp_cnt <= '0;
    end else begin
      hi_cnt <= lcd_scp ? hi_cnt + 1'b1 : '0;
      lp_cnt <= lcd_lp ? lp_cnt + 1'b1 : '0;
    end
  end

  a_r7_din_moves_on_scp_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lcd_din) |-> $rose(lcd_scp));

  a_r6_scp_high_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_scp |-> hi_cnt < C_W'(SCP_HALF));

  a_r2_lp_width_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_lp |-> lp_cnt < C_W'(LP_WIDTH));

  a_r9_quiet_during_lp: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_lp |-> (!lcd_scp && !fb_rd));

  a_r4_flm_falls_with_lp: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_flm) |-> $fell(lcd_lp));

  a_r5_frame_start_in_row0: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (lcd_flm && line_start && !lcd_lp));

  a_r3_fetch_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rd |=> !fb_rd);

endmodule

bind lcd_row_refresh lcd_row_refresh_chk #(
  .SCP_HALF(SCP_HALF),
  .LP_WIDTH(LP_WIDTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lcd_din    (lcd_din),
  .lcd_scp    (lcd_scp),
  .lcd_lp     (lcd_lp),
  .lcd_flm    (lcd_flm),
  .frame_start(frame_start),
  .fb_rd      (fb_rd),
  .line_start (line_start)
);

// File: tb/lcd_row_refresh_bench.sv
`timescale 1ns/1ps
module lcd_row_refresh_bench;

  localparam int ROWS   = 3;
  localparam int BITS   = 40;
  localparam int LINE   = 400;
  localparam int LPW    = 4;
  localparam int H      = 2;
  localparam int BPR    = BITS / 8;
  localparam int AW     = $clog2(ROWS * BPR);
  localparam int BYTE_T = 2 + 16 * H;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fb_rd;
  logic [AW-1:0] fb_addr;
  logic [7:0]    fb_data = 8'h00;
  logic          lcd_din, lcd_scp, lcd_lp, lcd_flm, frame_start;

  int total = 0;
  int bad   = 0;
  int n;
  logic model_din;
  logic prev_scp;
  int   rises;

  always #2.5 clk = ~clk;

  lcd_row_refresh #(
    .ROWS(ROWS), .BITS_PER_ROW(BITS), .LINE_CYCLES(LINE),
    .LP_WIDTH(LPW), .SCP_HALF(H)
  ) u_lcd_row_refresh (
    .clk(clk), .rst_n(rst_n), .fb_rd(fb_rd), .fb_addr(fb_addr),
    .fb_data(fb_data), .lcd_din(lcd_din), .lcd_scp(lcd_scp),
    .lcd_lp(lcd_lp), .lcd_flm(lcd_flm), .frame_start(frame_start)
  );

  function automatic logic [7:0] pix(int a);
    return 8'((a * 73 + 5) % 256);
  endfunction

  // synchronous frame buffer
  initial forever begin
    @(posedge clk);
    if (fb_rd) fb_data <= pix(int'(fb_addr));
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at n=%0d actual=%0d expected=%0d", tag, n, act, exp);
    end
  endtask

  task automatic compare_cycle();
    int t, p, row, seg, b, off, k, bi, w;
    bit e_lp, e_flm, e_fs, e_rd, e_scp;
    int e_addr;
    t = n % LINE; p = n / LINE; row = p % ROWS;
    e_lp  = (t >= LINE - LPW);
    e_flm = (row == 0);
    e_fs  = (t == 0) && (row == 0);
    e_rd  = 1'b0; e_scp = 1'b0; e_addr = 0;
    if (t >= 1) begin
      seg = t - 1; b = seg / BYTE_T; off = seg % BYTE_T;
      if (b < BPR) begin
        if (off == 0) begin
          e_rd = 1'b1; e_addr = row * BPR + b;
        end else if (off >= 2) begin
          k = off - 2; bi = k / (2 * H); w = k % (2 * H);
          e_scp = (w < H);
          if (w == 0) model_din = pix(row * BPR + b) >> (7 - bi);
        end
      end
    end
    chk(lcd_lp == e_lp, "R2 lcd_lp", lcd_lp, e_lp);
    chk(lcd_flm == e_flm, "R4 lcd_flm", lcd_flm, e_flm);
    chk(frame_start == e_fs, "R5 frame_start", frame_start, e_fs);
    chk(fb_rd == e_rd, "R3 fb_rd", fb_rd, e_rd);
    if (e_rd) begin
      chk(int'(fb_addr) == e_addr, "R3 fb_addr", fb_addr, e_addr);
      if (p >= ROWS && row == 0 && t == 1)
        chk(fb_addr == '0, "R8 wrap address", fb_addr, 0);
    end
    chk(lcd_scp == e_scp, "R6 lcd_scp", lcd_scp, e_scp);
    chk(lcd_din == model_din, "R7 lcd_din", lcd_din, model_din);
    if (lcd_scp && !prev_scp) rises++;
    prev_scp = lcd_scp;
    if (t == LINE - LPW) begin
      chk(rises == BITS, "R9 shift pulses before latch", rises, BITS);
      rises = 0;
    end
  endtask

  task automatic run_from_reset(input int cycles);
    rst_n = 1'b1;
    n = 0; model_din = 1'b0; prev_scp = 1'b0; rises = 0;
    compare_cycle();
    for (int i = 1; i < cycles; i++) begin
      @(negedge clk);
      n = i;
      compare_cycle();
    end
  endtask

  task automatic check_reset_state();
    chk(lcd_lp == 1'b0, "R1 reset lcd_lp", lcd_lp, 0);
    chk(lcd_scp == 1'b0, "R1 reset lcd_scp", lcd_scp, 0);
    chk(lcd_din == 1'b0, "R1 reset lcd_din", lcd_din, 0);
    chk(fb_rd == 1'b0, "R1 reset fb_rd", fb_rd, 0);
  endtask

  initial begin
    n = 0;
    repeat (3) @(negedge clk);
    check_reset_state();
    // two full frames plus one row, crossing every row boundary
    run_from_reset(LINE * (2 * ROWS + 1));
    // reset in the middle of a burst of the next row
    repeat (60) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state();
    run_from_reset(LINE * (ROWS + 1));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule